// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page table held in memory. A start strobe captures the linear address and the current page-directory base. The block then issues two reads through a request/valid memory port: first the directory entry, then the page-table entry that the directory entry points to. The physical address is the frame base from the second entry joined to the page offset of the linear address. Pages are 4096 bytes.

Each table entry is 32 bits. Bit 0 is the present flag, and bits 31:12 hold the frame base of the next level (the page table for a directory entry, the page frame for a table entry). If either entry has its present flag clear, the walk stops at once and reports a page fault. The walker handles one translation at a time and accepts a new one only when it is idle.

Top module: `ptw_top`

## Requirements
- R1: After reset, mem_req_o, done_o and fault_o are 0 and phys_addr_o is 0.
- R2: The first read goes to address {dir_base_i[31:12], 12'h000} + 4 * lin[31:22]. Bits 11:0 of dir_base_i are ignored.
- R3: When the directory entry has bit 0 set, the second read goes to address {dir_entry[31:12], 12'h000} + 4 * lin[21:12].
- R4: When the table entry has bit 0 set, done_o pulses with fault_o = 0 and phys_addr_o = {pte[31:12], lin[11:0]}. Exactly two reads are made.
- R5: A directory entry with bit 0 clear ends the walk after one read: done_o and fault_o pulse together, and no second read is issued.
- R6: A table entry with bit 0 clear ends the walk with done_o and fault_o set and phys_addr_o = 0, even when bits 31:12 of the entry are nonzero.
- R7: start_i is ignored from the cycle after a walk is accepted through the completion cycle. Raising it during that time does not start another read sequence or change the result.
- R8: mem_req_o stays high with mem_addr_o unchanged until mem_valid_i is seen, for any response latency. mem_valid_i has no effect while mem_req_o is low.
- R9: lin_addr_i and dir_base_i are sampled only on an accepted start. Changing them later in the walk does not change the read addresses or the result.
- R10: done_o is high for exactly one cycle per walk. fault_o is never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dir_base_i | input | 32 | Control register holding the page-directory base (bits 31:12 used) |
| start_i | input | 1 | Start strobe for a translation, taken only when idle |
| lin_addr_i | input | 32 | Linear address to translate |
| mem_req_o | output | 1 | Memory read request, held until answered |
| mem_addr_o | output | 32 | Byte address of the table entry being read |
| mem_valid_i | input | 1 | Read data is valid this cycle |
| mem_rdata_i | input | 32 | Table entry returned by memory |
| done_o | output | 1 | One-cycle pulse when a walk ends |
| fault_o | output | 1 | Set with done_o when a walk ends on a not-present entry |
| phys_addr_o | output | 32 | Translated physical address (zero after a fault) |

## Verification
The completion pulse and the start strobe can meet in the same cycle: a caller that sees done_o may raise start_i straight away while the walker is still in its ending state. The bench raises start_i in exactly the cycle where it sees done_o, with a different linear address. It also raises start_i several times during a slow walk while changing the address and base inputs. It then judges the result from the ports: the result of the first walk must not change, the read count must stay at two, and no further request may appear in the cycles that follow. A second overlap, a stray mem_valid_i while nothing is requested, is driven during idle and must produce neither a completion nor a request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_DIR,
        WALK_TBL,
        WALK_OK,
        WALK_FLT
    } walk_state_e;

    // entry bit that marks the next level as resident
    localparam int unsigned ENTRY_PRESENT_BIT = 0;

endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
    parameter  int ADDR_W = 32,
    parameter  int HI_W   = 10,
    parameter  int MID_W  = 10,
    localparam int OFS_W  = ADDR_W - HI_W - MID_W
) (
    input  logic [ADDR_W-1:0] lin_i,
    output logic [HI_W-1:0]   hi_o,
    output logic [MID_W-1:0]  mid_o,
    output logic [OFS_W-1:0]  ofs_o
);

    assign hi_o  = lin_i[ADDR_W-1 -: HI_W];
    assign mid_o = lin_i[OFS_W +: MID_W];
    assign ofs_o = lin_i[OFS_W-1:0];

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter  int ADDR_W      = 32,
    parameter  int FRAME_W     = 20,
    parameter  int IDX_W       = 10,
    parameter  int ENTRY_BYTES = 4,
    localparam int OFS_W       = ADDR_W - FRAME_W,
    localparam int SHIFT       = $clog2(ENTRY_BYTES)
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] step_w;

    assign base_w = {frame_i, {OFS_W{1'b0}}};
    assign step_w = ADDR_W'(idx_i) << SHIFT;
    assign addr_o = base_w + step_w;

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FRAME_W = 20
) (
    input  logic [ADDR_W-1:0]  entry_i,
    output logic               present_o,
    output logic [FRAME_W-1:0] frame_o
);

    assign present_o = entry_i[ENTRY_PRESENT_BIT];
    assign frame_o   = entry_i[ADDR_W-1 -: FRAME_W];

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter  int ADDR_W      = 32,
    parameter  int DIR_W       = 10,
    parameter  int TBL_W       = 10,
    parameter  int ENTRY_BYTES = 4,
    localparam int OFS_W       = ADDR_W - DIR_W - TBL_W,
    localparam int FRAME_W     = ADDR_W - OFS_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] dir_base_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] lin_addr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] phys_addr_o
);

    typedef struct packed {
        walk_state_e        st;
        logic [ADDR_W-1:0]  lin;
        logic [FRAME_W-1:0] root;
        logic [FRAME_W-1:0] tbl;
        logic [ADDR_W-1:0]  phys;
    } walk_s;

    walk_s walk_d, walk_q;

    logic [DIR_W-1:0]   dir_idx_w;
    logic [TBL_W-1:0]   tbl_idx_w;
    logic [OFS_W-1:0]   ofs_w;
    logic [ADDR_W-1:0]  dir_ent_addr_w;
    logic [ADDR_W-1:0]  tbl_ent_addr_w;
    logic               ent_present_w;
    logic [FRAME_W-1:0] ent_frame_w;

    ptw_index_split #(
        .ADDR_W (ADDR_W),
        .HI_W   (DIR_W),
        .MID_W  (TBL_W)
    ) u_split (
        .lin_i  (walk_q.lin),
        .hi_o   (dir_idx_w),
        .mid_o  (tbl_idx_w),
        .ofs_o  (ofs_w)
    );

    ptw_entry_addr #(
        .ADDR_W      (ADDR_W),
        .FRAME_W     (FRAME_W),
        .IDX_W       (DIR_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_dir_addr (
        .frame_i (walk_q.root),
        .idx_i   (dir_idx_w),
        .addr_o  (dir_ent_addr_w)
    );

    ptw_entry_addr #(
        .ADDR_W      (ADDR_W),
        .FRAME_W     (FRAME_W),
        .IDX_W       (TBL_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_tbl_addr (
        .frame_i (walk_q.tbl),
        .idx_i   (tbl_idx_w),
        .addr_o  (tbl_ent_addr_w)
    );

    ptw_entry_decode #(
        .ADDR_W  (ADDR_W),
        .FRAME_W (FRAME_W)
    ) u_decode (
        .entry_i   (mem_rdata_i),
        .present_o (ent_present_w),
        .frame_o   (ent_frame_w)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            WALK_IDLE: begin
                if (start_i) begin
                    walk_d.st   = WALK_DIR;
                    walk_d.lin  = lin_addr_i;
                    walk_d.root = dir_base_i[ADDR_W-1 -: FRAME_W];
                end
            end
            WALK_DIR: begin
                if (mem_valid_i) begin
                    if (ent_present_w) begin
                        walk_d.st  = WALK_TBL;
                        walk_d.tbl = ent_frame_w;
                    end else begin
                        walk_d.st   = WALK_FLT;
                        walk_d.phys = '0;
                    end
                end
            end
            WALK_TBL: begin
                if (mem_valid_i) begin
                    if (ent_present_w) begin
                        walk_d.st   = WALK_OK;
                        walk_d.phys = {ent_frame_w, ofs_w};
                    end else begin
                        walk_d.st   = WALK_FLT;
                        walk_d.phys = '0;
                    end
                end
            end
            WALK_OK:  walk_d.st = WALK_IDLE;
            WALK_FLT: walk_d.st = WALK_IDLE;
            default:  walk_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            walk_q.st   <= WALK_IDLE;
            walk_q.lin  <= '0;
            walk_q.root <= '0;
            walk_q.tbl  <= '0;
            walk_q.phys <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mem_req_o   = (walk_q.st == WALK_DIR) || (walk_q.st == WALK_TBL);
    assign mem_addr_o  = (walk_q.st == WALK_TBL) ? tbl_ent_addr_w : dir_ent_addr_w;
    assign done_o      = (walk_q.st == WALK_OK) || (walk_q.st == WALK_FLT);
    assign fault_o     = (walk_q.st == WALK_FLT);
    assign phys_addr_o = walk_q.phys;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_i,
    input logic              done_o,
    input logic              fault_o,
    input logic [ADDR_W-1:0] phys_addr_o
);

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R8

    AST_FAULT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> done_o); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10

    AST_NO_REQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !mem_req_o); // R5

    AST_FAULT_ZERO_PHYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (phys_addr_o == '0)); // R6

    AST_IDLE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !mem_req_o); // R7

endmodule

bind ptw_top ptw_checker #(.ADDR_W(ADDR_W)) u_ptw_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .phys_addr_o (phys_addr_o)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] dir_base_i = '0;
    logic        start_i = 1'b0;
    logic [31:0] lin_addr_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o;
    logic        fault_o;
    logic [31:0] phys_addr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // memory model state
    logic [31:0] pmem [logic [31:0]];
    int          lat = 0;
    int          cnt = 0;
    bit          stray = 1'b0;
    int          nresp = 0;
    logic [31:0] rlog [0:3];

    always #5 clk_i = ~clk_i;

    ptw_top dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dir_base_i  (dir_base_i),
        .start_i     (start_i),
        .lin_addr_i  (lin_addr_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_valid_i (mem_valid_i),
        .mem_rdata_i (mem_rdata_i),
        .done_o      (done_o),
        .fault_o     (fault_o),
        .phys_addr_o (phys_addr_o)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    always @(negedge clk_i) begin
        if (stray) begin
            mem_valid_i = 1'b1;
            mem_rdata_i = 32'hFFFF_FFFF;
        end else if (mem_valid_i) begin
            mem_valid_i = 1'b0;
            cnt = 0;
        end else if (mem_req_o) begin
            if (cnt >= lat) begin
                mem_valid_i = 1'b1;
                mem_rdata_i = rd(mem_addr_o);
                if (nresp < 4) rlog[nresp] = mem_addr_o;
                nresp++;
                cnt = 0;
            end else begin
                cnt++;
            end
        end else begin
            cnt = 0;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] lin, input logic [31:0] root);
        @(negedge clk_i);
        nresp = 0;
        lin_addr_i = lin;
        dir_base_i = root;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 60) begin
            @(negedge clk_i);
            n++;
        end
        if (!done_o) check_eq({tag, " walk did not end"}, 32'h0, 32'h1);
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_i);
            check_eq(tag, {30'h0, mem_req_o, done_o}, 32'h0);
        end
    endtask

    task automatic test_reset;
        check_eq("R1 req", {31'h0, mem_req_o}, 32'h0);
        check_eq("R1 done", {31'h0, done_o}, 32'h0);
        check_eq("R1 fault", {31'h0, fault_o}, 32'h0);
        check_eq("R1 phys", phys_addr_o, 32'h0);
    endtask

    task automatic test_basic;
        lat = 0;
        launch(32'h0040_3ABC, 32'h0010_0000);
        wait_done("R4");
        check_eq("R2 dir entry address", rlog[0], 32'h0010_0004);
        check_eq("R3 table entry address", rlog[1], 32'h0020_000C);
        check_eq("R4 phys", phys_addr_o, 32'h0ABC_DABC);
        check_eq("R4 no fault", {31'h0, fault_o}, 32'h0);
        check_eq("R4 read count", nresp, 2);
        @(negedge clk_i);
        check_eq("R10 done one cycle", {31'h0, done_o}, 32'h0);
    endtask

    task automatic test_slow_max_index;
        lat = 3;
        launch(32'hFFFF_F123, 32'h0030_0ABC);
        wait_done("R8");
        check_eq("R2 masked base, top index", rlog[0], 32'h0030_0FFC);
        check_eq("R3 top table index", rlog[1], 32'h0040_0FFC);
        check_eq("R8 phys after slow reads", phys_addr_o, 32'h1234_5123);
        check_eq("R8 read count", nresp, 2);
        @(negedge clk_i);
        check_eq("R10 done one cycle slow", {31'h0, done_o}, 32'h0);
    endtask

    task automatic test_dir_fault;
        lat = 1;
        launch(32'h0080_0000, 32'h0010_0000);
        wait_done("R5");
        check_eq("R5 fault", {31'h0, fault_o}, 32'h1);
        check_eq("R5 dir address", rlog[0], 32'h0010_0008);
        check_eq("R5 single read", nresp, 1);
        check_eq("R5 phys zero", phys_addr_o, 32'h0);
        expect_quiet(5, "R5 no read after fault");
        check_eq("R5 still single read", nresp, 1);
    endtask

    task automatic test_tbl_fault;
        lat = 0;
        launch(32'h0040_5000, 32'h0010_0000);
        wait_done("R6");
        check_eq("R6 fault", {31'h0, fault_o}, 32'h1);
        check_eq("R6 table address", rlog[1], 32'h0020_0014);
        check_eq("R6 phys zero", phys_addr_o, 32'h0);
        check_eq("R6 two reads", nresp, 2);
    endtask

    task automatic test_start_ignored;
        lat = 4;
        launch(32'h0040_3ABC, 32'h0010_0000);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_i);
            start_i = (i % 2 == 0);
            lin_addr_i = 32'hFFFF_F123 ^ i;
            dir_base_i = 32'h0030_0000;
        end
        start_i = 1'b0;
        wait_done("R7");
        // start raised in the completion cycle itself
        start_i = 1'b1;
        lin_addr_i = 32'h0080_0000;
        check_eq("R9 dir address from sampled inputs", rlog[0], 32'h0010_0004);
        check_eq("R9 table address", rlog[1], 32'h0020_000C);
        check_eq("R7 phys unchanged", phys_addr_o, 32'h0ABC_DABC);
        check_eq("R7 read count", nresp, 2);
        @(negedge clk_i);
        start_i = 1'b0;
        expect_quiet(4, "R7 start in done cycle ignored");
        check_eq("R7 phys held", phys_addr_o, 32'h0ABC_DABC);
    endtask

    task automatic test_stray_valid;
        @(negedge clk_i);
        stray = 1'b1;
        @(negedge clk_i);
        @(negedge clk_i);
        stray = 1'b0;
        expect_quiet(3, "R8 stray valid ignored");
        check_eq("R8 phys after stray", phys_addr_o, 32'h0ABC_DABC);
    endtask

    task automatic test_back_to_back;
        lat = 0;
        launch(32'hFFFF_F123, 32'h0030_0000);
        wait_done("R4 back to back");
        check_eq("R4 second walk phys", phys_addr_o, 32'h1234_5123);
        check_eq("R4 second walk no fault", {31'h0, fault_o}, 32'h0);
    endtask

    initial begin
        pmem[32'h0010_0004] = 32'h0020_0001;
        pmem[32'h0020_000C] = 32'h0ABC_D003;
        pmem[32'h0030_0FFC] = 32'h0040_0FFF;
        pmem[32'h0040_0FFC] = 32'h1234_5001;
        pmem[32'h0020_0014] = 32'hFFFF_F000;
        repeat (3) @(negedge clk_i);
        test_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        test_basic();
        test_slow_max_index();
        test_dir_fault();
        test_tbl_fault();
        test_start_ignored();
        test_stray_valid();
        test_back_to_back();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual %0d expected 0", 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule